// File: doc/BRIEF.md
# Indirect Register Window with Post-Incrementing Data Port

This block sits behind a byte-wide register bus (address, write data, read data, write and read strobes). Only a handful of direct registers are visible there. A 24-bit internal address is assembled from three address-byte registers. A single data-port register then reads or writes the internal location that address selects, and moves the address on by one after every access. Software can therefore set the address once and stream through consecutive internal locations.

Two structures sit behind the window. The first is a table of line-mode entries. Each entry is a pair of bytes: a line number followed by a mode byte. The second is a bank of thirteen sliced VPS bytes, which a data producer loads through a side port and which software can only read. A small status register carries three event flags that hardware sets. Software clears them by writing a mask to a separate clear register. The bus front end and the data producers are outside this block and appear only as plain ports.

Top module: `ind_reg_window`

## Requirements
- R1: Direct registers E8h, E9h and EAh hold bits 7:0, 15:8 and 23:16 of the internal address. Writing one of them loads that byte, reading it returns that byte, and the address holds when no address register or data port is accessed. After reset the address is 000000h.
- R2: A write to the data port E1h stores the byte at the current internal address and then increments the address by one.
- R3: A read of the data port E1h returns the byte at the current internal address and then increments the address by one.
- R4: The increment carries across all 24 bits. 8006FFh becomes 800700h, and FFFFFFh wraps to 000000h.
- R5: Line-mode entry i sits at 800600h + 2i (line number) and 800600h + 2i + 1 (mode byte), for i from 0 to 8. Both bytes are readable and writable. Reset sets line numbers to 00h and mode bytes to FFh, where FFh means the entry is unused.
- R6: VPS byte k (k from 0 to 12) reads at 800700h + k. It is loaded only by the producer port (write enable, 4-bit index, data), and producer indices above 12 are ignored. A data-port write to this range leaves the stored byte unchanged but still increments the address.
- R7: Internal addresses outside the line-mode and VPS ranges read as 00h, and writes to them have no effect. Direct addresses other than E1h, E8h–EAh and F0h read as 00h.
- R8: Status register F0h reads bit 7 = FIFO threshold reached, bit 6 = teletext data available, bit 4 = VPS data available, and all other bits 0. A one-cycle pulse on the matching set input sets the bit, and it stays set until cleared. Writes to F0h have no effect.
- R9: Writing a mask to F6h clears every status bit whose mask bit is 1 and leaves the others unchanged.
- R10: A status bit whose set input pulses in the same cycle as a clear write to it remains set.
- R11: Read data is registered. It appears on the read-data port in the cycle after the read strobe and holds until the next read. It is 00h after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Direct register address |
| regWrData | input | 8 | Direct register write data |
| regWrEn | input | 1 | Write strobe, one access per cycle |
| regRdEn | input | 1 | Read strobe, one access per cycle |
| regRdData | output | 8 | Registered read data |
| fifoThreshSet | input | 1 | Sets status bit 7 |
| ttxAvailSet | input | 1 | Sets status bit 6 |
| vpsAvailSet | input | 1 | Sets status bit 4 |
| vpsWrEn | input | 1 | Producer load strobe for the VPS bank |
| vpsWrIdx | input | 4 | Producer byte index (0 to 12) |
| vpsWrData | input | 8 | Producer byte value |

## Verification
The assertions assume the bus never raises the write and read strobes in the same cycle. The decoder gives the write priority in that case, but the checks on address stepping and read-data holding are only meaningful when accesses are exclusive. Every bench task drives exactly one strobe for one cycle and lowers it before the next access. The bench also pulses the status set inputs and the producer port only at the falling edge, so the set-versus-clear race is created on purpose and in only one place.

// File: rtl/ind_win_pkg.sv
package ind_win_pkg;

  // Direct register map
  localparam logic [7:0] ADDR_DATA     = 8'hE1;
  localparam logic [7:0] ADDR_LO       = 8'hE8;
  localparam logic [7:0] ADDR_MID      = 8'hE9;
  localparam logic [7:0] ADDR_HI       = 8'hEA;
  localparam logic [7:0] ADDR_STAT     = 8'hF0;
  localparam logic [7:0] ADDR_STAT_CLR = 8'hF6;

  // Status bit positions
  localparam int STAT_THRESH_BIT = 7;
  localparam int STAT_TTX_BIT    = 6;
  localparam int STAT_VPS_BIT    = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LO,
    RD_MID,
    RD_HI,
    RD_WIN,
    RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic   loadLo;
    logic   loadMid;
    logic   loadHi;
    logic   winWr;
    logic   winRd;
    logic   statClr;
    logic   rdEn;
    rdSel_e rdSel;
  } winStrobe_t;

endpackage

// File: rtl/ind_win_ctrl.sv
module ind_win_ctrl
  import ind_win_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  output winStrobe_t strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (regWrEn) begin
      case (regAddr)
        ADDR_LO:       strb.loadLo  = 1'b1;
        ADDR_MID:      strb.loadMid = 1'b1;
        ADDR_HI:       strb.loadHi  = 1'b1;
        ADDR_DATA:     strb.winWr   = 1'b1;
        ADDR_STAT_CLR: strb.statClr = 1'b1;
        default: ;
      endcase
    end else if (regRdEn) begin
      strb.rdEn = 1'b1;
      case (regAddr)
        ADDR_LO:   strb.rdSel = RD_LO;
        ADDR_MID:  strb.rdSel = RD_MID;
        ADDR_HI:   strb.rdSel = RD_HI;
        ADDR_STAT: strb.rdSel = RD_STAT;
        ADDR_DATA: begin
          strb.rdSel = RD_WIN;
          strb.winRd = 1'b1;
        end
        default:   strb.rdSel = RD_NONE;
      endcase
    end
  end

  // Input assumption: one bus access per cycle (R11 read timing relies on it)
  p_one_access_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

// File: rtl/ind_win_datapath.sv
module ind_win_datapath
  import ind_win_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          NUM_LINES = 9,
  parameter int          VPS_BYTES = 13,
  parameter logic [23:0] LINE_BASE = 24'h800600,
  parameter logic [23:0] VPS_BASE  = 24'h800700,
  localparam int         VPS_IDX_W = $clog2(VPS_BYTES)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strb,
  input  logic [7:0]           regWrData,
  input  logic                 fifoThreshSet,
  input  logic                 ttxAvailSet,
  input  logic                 vpsAvailSet,
  input  logic                 vpsWrEn,
  input  logic [VPS_IDX_W-1:0] vpsWrIdx,
  input  logic [7:0]           vpsWrData,
  output logic [7:0]           regRdData
);

  localparam int LINE_SPAN = 2 * NUM_LINES;

  logic [ADDR_W-1:0] winAddr;
  logic [ADDR_W-1:0] lineOff;
  logic [ADDR_W-1:0] vpsOff;
  logic [7:0]        lineNum  [NUM_LINES];
  logic [7:0]        lineMode [NUM_LINES];
  logic [7:0]        vpsBank  [VPS_BYTES];
  logic [7:0]        winRdVal;
  logic              statThresh, statTtx, statVps;
  logic [7:0]        statusVec;
  logic              addrStep;

  assign addrStep = strb.winWr || strb.winRd;
  assign lineOff  = winAddr - ADDR_W'(LINE_BASE);
  assign vpsOff   = winAddr - ADDR_W'(VPS_BASE);

  // Internal address: byte loads and post-increment after each window access
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winAddr <= '0;
    end else if (strb.loadLo) begin
      winAddr[7:0] <= regWrData;
    end else if (strb.loadMid) begin
      winAddr[15:8] <= regWrData;
    end else if (strb.loadHi) begin
      winAddr[23:16] <= regWrData;
    end else if (addrStep) begin
      winAddr <= winAddr + ADDR_W'(1);
    end
  end

  // Line-mode entries: a line byte then a mode byte
  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineNum[gi]  <= 8'h00;
        lineMode[gi] <= 8'hFF;
      end else if (strb.winWr) begin
        if (lineOff == ADDR_W'(2 * gi))
          lineNum[gi] <= regWrData;
        if (lineOff == ADDR_W'(2 * gi + 1))
          lineMode[gi] <= regWrData;
      end
    end
  end

  // VPS bank: loaded only by the producer
  for (genvar gk = 0; gk < VPS_BYTES; gk++) begin : g_vps
    always_ff @(posedge clk) begin
      if (!rstN)
        vpsBank[gk] <= 8'h00;
      else if (vpsWrEn && (vpsWrIdx == VPS_IDX_W'(gk)))
        vpsBank[gk] <= vpsWrData;
    end

    // R6: the bank never changes without a producer load for this byte
    p_vps_readonly_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(vpsWrEn && (vpsWrIdx == VPS_IDX_W'(gk))) |=> $stable(vpsBank[gk]));
  end

  // Window read value
  always_comb begin
    winRdVal = 8'h00;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (lineOff == ADDR_W'(2 * i))     winRdVal = lineNum[i];
      if (lineOff == ADDR_W'(2 * i + 1)) winRdVal = lineMode[i];
    end
    for (int k = 0; k < VPS_BYTES; k++) begin
      if (vpsOff == ADDR_W'(k)) winRdVal = vpsBank[k];
    end
  end

  // Status flags: a set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statThresh <= 1'b0;
      statTtx    <= 1'b0;
      statVps    <= 1'b0;
    end else begin
      statThresh <= fifoThreshSet |
                    (statThresh & ~(strb.statClr & regWrData[STAT_THRESH_BIT]));
      statTtx    <= ttxAvailSet |
                    (statTtx & ~(strb.statClr & regWrData[STAT_TTX_BIT]));
      statVps    <= vpsAvailSet |
                    (statVps & ~(strb.statClr & regWrData[STAT_VPS_BIT]));
    end
  end

  always_comb begin
    statusVec                  = 8'h00;
    statusVec[STAT_THRESH_BIT] = statThresh;
    statusVec[STAT_TTX_BIT]    = statTtx;
    statusVec[STAT_VPS_BIT]    = statVps;
  end

  // Registered read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= 8'h00;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_LO:   regRdData <= winAddr[7:0];
        RD_MID:  regRdData <= winAddr[15:8];
        RD_HI:   regRdData <= winAddr[23:16];
        RD_WIN:  regRdData <= winRdVal;
        RD_STAT: regRdData <= statusVec;
        default: regRdData <= 8'h00;
      endcase
    end
  end

  // R2/R3/R4: every window access steps the 24-bit address by one, wrapping
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrStep |=> (winAddr == $past(winAddr) + ADDR_W'(1)));

  // R1: address holds without a load or window access
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(addrStep || strb.loadLo || strb.loadMid || strb.loadHi) |=> $stable(winAddr));

  // R10: a set pulse always leaves its flag set
  p_thresh_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoThreshSet |=> statThresh);
  p_ttx_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    ttxAvailSet |=> statTtx);
  p_vps_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    vpsAvailSet |=> statVps);

  // R9: a masked clear without a concurrent set drops the flag
  p_thresh_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statClr && regWrData[STAT_THRESH_BIT] && !fifoThreshSet) |=> !statThresh);

  // R11: read data holds between reads
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(regRdData));

endmodule

// File: rtl/ind_reg_window.sv
module ind_reg_window
  import ind_win_pkg::*;
#(
  parameter int  NUM_LINES = 9,
  parameter int  VPS_BYTES = 13,
  localparam int VPS_IDX_W = $clog2(VPS_BYTES)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           regAddr,
  input  logic [7:0]           regWrData,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  output logic [7:0]           regRdData,
  input  logic                 fifoThreshSet,
  input  logic                 ttxAvailSet,
  input  logic                 vpsAvailSet,
  input  logic                 vpsWrEn,
  input  logic [VPS_IDX_W-1:0] vpsWrIdx,
  input  logic [7:0]           vpsWrData
);

  winStrobe_t strb;

  ind_win_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  ind_win_datapath #(
    .ADDR_W    (24),
    .NUM_LINES (NUM_LINES),
    .VPS_BYTES (VPS_BYTES),
    .LINE_BASE (24'h800600),
    .VPS_BASE  (24'h800700)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .regWrData     (regWrData),
    .fifoThreshSet (fifoThreshSet),
    .ttxAvailSet   (ttxAvailSet),
    .vpsAvailSet   (vpsAvailSet),
    .vpsWrEn       (vpsWrEn),
    .vpsWrIdx      (vpsWrIdx),
    .vpsWrData     (vpsWrData),
    .regRdData     (regRdData)
  );

endmodule

// File: tb/ind_reg_window_tb_top.sv
module ind_reg_window_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       fifoThreshSet = 1'b0;
  logic       ttxAvailSet = 1'b0;
  logic       vpsAvailSet = 1'b0;
  logic       vpsWrEn = 1'b0;
  logic [3:0] vpsWrIdx = 4'h0;
  logic [7:0] vpsWrData = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ind_reg_window dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData),
    .fifoThreshSet(fifoThreshSet), .ttxAvailSet(ttxAvailSet),
    .vpsAvailSet(vpsAvailSet), .vpsWrEn(vpsWrEn), .vpsWrIdx(vpsWrIdx),
    .vpsWrData(vpsWrData)
  );

  typedef struct packed {
    logic       isRd;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hE8, 8'h00, 8'd1},   // R1 load low
    '{1'b0, 8'hE9, 8'h06, 8'd1},   // R1 load mid
    '{1'b0, 8'hEA, 8'h80, 8'd1},   // R1 load high
    '{1'b1, 8'hE8, 8'h00, 8'd1},   // R1 readback
    '{1'b1, 8'hE9, 8'h06, 8'd1},
    '{1'b1, 8'hEA, 8'h80, 8'd1},
    '{1'b0, 8'hE1, 8'h10, 8'd2},   // R2 line 0 = 16
    '{1'b0, 8'hE1, 8'h34, 8'd2},   // R2 mode 0
    '{1'b1, 8'hE8, 8'h02, 8'd2},   // R2 two increments
    '{1'b0, 8'hE8, 8'h00, 8'd1},
    '{1'b1, 8'hE1, 8'h10, 8'd3},   // R3 read line 0
    '{1'b1, 8'hE1, 8'h34, 8'd3},   // R3 read mode 0
    '{1'b1, 8'hE1, 8'h00, 8'd5},   // R5 line 1 reset value
    '{1'b1, 8'hE1, 8'hFF, 8'd5},   // R5 mode 1 reset value (unused)
    '{1'b1, 8'hE8, 8'h04, 8'd3},   // R3 four increments
    '{1'b0, 8'hE8, 8'h10, 8'd5},   // R5 last entry at 800610h
    '{1'b0, 8'hE1, 8'h1F, 8'd5},
    '{1'b0, 8'hE1, 8'h77, 8'd5},
    '{1'b0, 8'hE1, 8'hAB, 8'd7},   // R7 800612h unmapped write
    '{1'b0, 8'hE8, 8'h10, 8'd5},
    '{1'b1, 8'hE1, 8'h1F, 8'd5},
    '{1'b1, 8'hE1, 8'h77, 8'd5},
    '{1'b1, 8'hE1, 8'h00, 8'd7},   // R7 unmapped reads zero
    '{1'b1, 8'hC3, 8'h00, 8'd7}    // R7 unmapped direct address
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    check(tag, regRdData, exp);
  endtask

  task automatic setAddr(input logic [23:0] a);
    regWrite(8'hE8, a[7:0]);
    regWrite(8'hE9, a[15:8]);
    regWrite(8'hEA, a[23:16]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset read data", regRdData, 8'h00);
    regRead(8'hE8, 8'h00, "R1 reset addr low");
    regRead(8'hEA, 8'h00, "R1 reset addr high");
    regRead(8'hF0, 8'h00, "R8 reset status");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].isRd)
        regRead(VECS[v].addr, VECS[v].data, $sformatf("R%0d vector %0d", VECS[v].req, v));
      else
        regWrite(VECS[v].addr, VECS[v].data);
    end

    // R6: producer loads, software reads, window writes ignored
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      vpsWrEn = 1'b1; vpsWrIdx = 4'(k); vpsWrData = 8'h40 + 8'(k);
    end
    @(negedge clk);
    vpsWrEn = 1'b0;
    setAddr(24'h800700);
    for (int k = 0; k < 13; k++)
      regRead(8'hE1, 8'h40 + 8'(k), "R6 VPS byte read");
    regRead(8'hE1, 8'h00, "R6 index beyond bank / R7 unmapped");
    regWrite(8'hE8, 8'h03);
    regWrite(8'hE1, 8'h55);
    regRead(8'hE8, 8'h04, "R6 write still increments");
    regWrite(8'hE8, 8'h03);
    regRead(8'hE1, 8'h43, "R6 read-only byte unchanged");

    // R4: carry and wrap
    setAddr(24'h8006FF);
    regRead(8'hE1, 8'h00, "R4 unmapped at 8006FF");
    regRead(8'hE9, 8'h07, "R4 carry into mid byte");
    regRead(8'hE8, 8'h00, "R4 low byte after carry");
    setAddr(24'hFFFFFF);
    regWrite(8'hE1, 8'h99);
    regRead(8'hEA, 8'h00, "R4 wrap high byte");
    regRead(8'hE9, 8'h00, "R4 wrap mid byte");
    regRead(8'hE8, 8'h00, "R4 wrap low byte");

    // R8: set pulses
    @(negedge clk); fifoThreshSet = 1'b1;
    @(negedge clk); fifoThreshSet = 1'b0; ttxAvailSet = 1'b1;
    @(negedge clk); ttxAvailSet = 1'b0; vpsAvailSet = 1'b1;
    @(negedge clk); vpsAvailSet = 1'b0;
    repeat (3) @(negedge clk);
    regRead(8'hF0, 8'hD0, "R8 all flags set and held");
    regWrite(8'hF0, 8'h00);
    regRead(8'hF0, 8'hD0, "R8 write to status ignored");
    // R9: masked clear
    regWrite(8'hF6, 8'h40);
    regRead(8'hF0, 8'h90, "R9 clear teletext flag only");
    // R10: set and clear in the same cycle
    @(negedge clk);
    regAddr = 8'hF6; regWrData = 8'h90; regWrEn = 1'b1; fifoThreshSet = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; fifoThreshSet = 1'b0;
    regRead(8'hF0, 8'h80, "R10 set wins over clear; R9 VPS cleared");

    // R11: read data holds
    repeat (4) @(negedge clk);
    check("R11 read data holds", regRdData, 8'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule